// File: doc/BRIEF.md
# Read-First Synchronous RAM with Delayed Write Commit

This block is a single-clock multi-port memory with lane write enables. A read that meets a write to the same address at the same clock edge returns the old contents. The storage array has no read-before-write ordering of its own. Instead, every write port is held in a register stage for one cycle, and the array is updated only from that stage. Each read port then forwards any pending registered write whose address matches its own, so reads that follow a write still see the new data on the very next edge.

Every port runs on the rising edge of one clock. Reads are registered. A read sampled at edge k shows the memory as it stood just before edge k. That view includes every write sampled at edge k-1 or earlier and none sampled at edge k. Lane enables are held in the register stage per group of EN_GROUP adjacent lanes, and each group bit is fanned back out to the lanes of its group. When several write ports hit the same address at one edge, the higher-numbered port wins each lane.

Top module: `rf_delayed_ram`

## Requirements
- R1: While rst_n is low at a rising edge, every rd_data word becomes zero. The write stage enables are cleared, so nothing is committed at the first edge after reset is released.
- R2: A write sampled at an edge where rst_n is low is never stored.
- R3: A read and a write to the same address sampled at the same edge make the read return the contents from before that write.
- R4: A read sampled one edge after a write to its address returns the written lanes (forwarded from the pending stage).
- R5: A read sampled two or more edges after a write returns the written data from the array.
- R6: Lane l covers data bits [l*DW/LANES +: DW/LANES]. Lanes whose group is disabled keep their old contents.
- R7: When several write ports write one lane of one address at the same edge, the highest-indexed port's data is kept, both in later array reads and in forwarded reads.
- R8: While rd_en of a read port is low, its rd_data holds its previous value.
- R9: Lanes are grouped as g = l / EN_GROUP. A group is written when any lane enable inside it is set, and then all lanes of the group take the new data.
- R10: Each read port forwards and reads independently at its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_addr | input | NWR*AW | Write addresses, port p at [p*AW +: AW] |
| wr_data | input | NWR*DW | Write data, port p at [p*DW +: DW] |
| wr_lane_en | input | NWR*LANES | Lane enables, port p at [p*LANES +: LANES] |
| rd_addr | input | NRD*AW | Read addresses, port r at [r*AW +: AW] |
| rd_en | input | NRD | Read enables, one per read port |
| rd_data | output | NRD*DW | Registered read data, port r at [r*DW +: DW] |

## Verification
The bench first fills an eight-word memory completely. It then drives directed collisions: a read at the same edge as a write, one edge after it, and two edges after it. A design that commits writes at once would return new data at the same edge. A design that leaves out forwarding would return stale data one edge later. It checks two write ports hitting one address with full and partial lanes, where a wrong priority shows up as the lower port's lanes. It checks partial group enables, where fanning out per lane instead of per group leaves half-written groups. It checks writes during reset, which must vanish. A long random phase over a four-address window compares every read port each cycle with a plain read-first model that applies writes immediately after sampling reads.

// File: rtl/rfram_pkg.sv
// Package: shared helpers for the delayed-write read-first RAM.
// Assumes data width divides evenly into lanes and lanes into groups.
package rfram_pkg;

    // Width in bits of one byte lane.
    function automatic int lane_width(input int dw, input int lanes);
        return dw / lanes;
    endfunction

    // Number of registered enable bits for a lane count and group size.
    function automatic int group_count(input int lanes, input int grp);
        return lanes / grp;
    endfunction

endpackage

// File: rtl/rfw_wr_delay.sv
// Module: rfw_wr_delay
// Holds one write port for one clock cycle. Address and data registers
// carry no reset; they are ignored while the held enables are zero.
// Enables are stored as one bit per group of EN_GROUP adjacent lanes
// (set when any lane of the group is set) and fanned back out per lane.
// Assumes LANES is a multiple of EN_GROUP.
module rfw_wr_delay
    import rfram_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 16,
    parameter int LANES    = 2,
    parameter int EN_GROUP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    in_addr,
    input  logic [DW-1:0]    in_data,
    input  logic [LANES-1:0] in_lane_en,
    output logic [AW-1:0]    q_addr,
    output logic [DW-1:0]    q_data,
    output logic [LANES-1:0] q_lane_en
);
    localparam int NGRP = group_count(LANES, EN_GROUP);

    logic [NGRP-1:0] grp_en_d;
    logic [NGRP-1:0] grp_en_q;

    // Reduce each lane group to one enable bit.
    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            grp_en_d[g] = |in_lane_en[g*EN_GROUP +: EN_GROUP];
        end
    end

    // Register group enables; cleared in reset so nothing stale commits.
    always_ff @(posedge clk) begin
        if (!rst_n) grp_en_q <= '0;
        else        grp_en_q <= grp_en_d;
    end

    // Register address and data without reset (don't-care when disabled).
    always_ff @(posedge clk) begin
        q_addr <= in_addr;
        q_data <= in_data;
    end

    // Fan each group enable back out to its lanes.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            q_lane_en[l] = grp_en_q[l / EN_GROUP];
        end
    end

    AST_EN_CLEARED: assert property (@(posedge clk)
        !rst_n |=> (q_lane_en == '0)); // R1

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        AST_GROUP_EN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (q_lane_en[g*EN_GROUP +: EN_GROUP] ==
                       {EN_GROUP{|$past(in_lane_en[g*EN_GROUP +: EN_GROUP])}})); // R9
    end

endmodule

// File: rtl/rfw_store.sv
// Module: rfw_store
// Storage array committed only from the held write stage. Ports are
// applied in index order so the highest port wins a shared lane.
// Provides an unregistered word per read address for the read ports.
// Assumes the array needs no reset value.
module rfw_store
    import rfram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DW    = 16,
    parameter int LANES = 2,
    parameter int NWR   = 2,
    parameter int NRD   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NWR*AW-1:0]    pend_addr,
    input  logic [NWR*DW-1:0]    pend_data,
    input  logic [NWR*LANES-1:0] pend_en,
    input  logic [NRD*AW-1:0]    rd_addr,
    output logic [NRD*DW-1:0]    arr_word
);
    localparam int LW    = lane_width(DW, LANES);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Commit held writes lane by lane; later ports overwrite earlier ones.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NWR; p++) begin
            for (int l = 0; l < LANES; l++) begin
                if (pend_en[p*LANES + l]) begin
                    mem[pend_addr[p*AW +: AW]][l*LW +: LW] <= pend_data[p*DW + l*LW +: LW];
                end
            end
        end
    end

    // Look up the current array word for each read address.
    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            arr_word[r*DW +: DW] = mem[rd_addr[r*AW +: AW]];
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_TOP_PORT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
            pend_en[(NWR-1)*LANES + l] |=>
            (mem[$past(pend_addr[(NWR-1)*AW +: AW])][l*LW +: LW] ==
             $past(pend_data[(NWR-1)*DW + l*LW +: LW]))); // R7
    end

endmodule

// File: rtl/rfw_rd_port.sv
// Module: rfw_rd_port
// One registered read port. Forwards lanes of any held write whose
// address matches, highest write port last, over the array word.
// Assumes the array word reflects all commits before this edge.
module rfw_rd_port
    import rfram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DW    = 16,
    parameter int LANES = 2,
    parameter int NWR   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        rd_addr,
    input  logic                 rd_en,
    input  logic [DW-1:0]        arr_word,
    input  logic [NWR*AW-1:0]    pend_addr,
    input  logic [NWR*DW-1:0]    pend_data,
    input  logic [NWR*LANES-1:0] pend_en,
    output logic [DW-1:0]        rd_data
);
    localparam int LW = lane_width(DW, LANES);

    logic [DW-1:0] fwd_word;

    // Overlay matching held writes onto the array word, lane by lane.
    always_comb begin
        fwd_word = arr_word;
        for (int p = 0; p < NWR; p++) begin
            for (int l = 0; l < LANES; l++) begin
                if (pend_en[p*LANES + l] && (pend_addr[p*AW +: AW] == rd_addr)) begin
                    fwd_word[l*LW +: LW] = pend_data[p*DW + l*LW +: LW];
                end
            end
        end
    end

    // Register the read result; hold when not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= fwd_word;
    end

    AST_RD_RESET: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0)); // R1

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R8

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_FWD_TOP_PORT: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && pend_en[(NWR-1)*LANES + l] && (pend_addr[(NWR-1)*AW +: AW] == rd_addr))
            |=> (rd_data[l*LW +: LW] == $past(pend_data[(NWR-1)*DW + l*LW +: LW]))); // R4
    end

endmodule

// File: rtl/rf_delayed_ram.sv
// Module: rf_delayed_ram
// Read-first multi-port RAM. Each write port passes through a one-cycle
// register stage before the array; read ports forward from that stage.
// Assumes one clock, rising edge, for every port; DW divisible by LANES
// and LANES divisible by EN_GROUP.
module rf_delayed_ram
    import rfram_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 16,
    parameter int LANES    = 2,
    parameter int EN_GROUP = 1,
    parameter int NWR      = 2,
    parameter int NRD      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NWR*AW-1:0]    wr_addr,
    input  logic [NWR*DW-1:0]    wr_data,
    input  logic [NWR*LANES-1:0] wr_lane_en,
    input  logic [NRD*AW-1:0]    rd_addr,
    input  logic [NRD-1:0]       rd_en,
    output logic [NRD*DW-1:0]    rd_data
);
    logic [NWR*AW-1:0]    pend_addr;
    logic [NWR*DW-1:0]    pend_data;
    logic [NWR*LANES-1:0] pend_en;
    logic [NRD*DW-1:0]    arr_word;

    for (genvar p = 0; p < NWR; p++) begin : g_wr
        rfw_wr_delay #(
            .AW(AW), .DW(DW), .LANES(LANES), .EN_GROUP(EN_GROUP)
        ) u_delay (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_addr   (wr_addr[p*AW +: AW]),
            .in_data   (wr_data[p*DW +: DW]),
            .in_lane_en(wr_lane_en[p*LANES +: LANES]),
            .q_addr    (pend_addr[p*AW +: AW]),
            .q_data    (pend_data[p*DW +: DW]),
            .q_lane_en (pend_en[p*LANES +: LANES])
        );
    end

    rfw_store #(
        .AW(AW), .DW(DW), .LANES(LANES), .NWR(NWR), .NRD(NRD)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_addr(pend_addr),
        .pend_data(pend_data),
        .pend_en  (pend_en),
        .rd_addr  (rd_addr),
        .arr_word (arr_word)
    );

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        rfw_rd_port #(
            .AW(AW), .DW(DW), .LANES(LANES), .NWR(NWR)
        ) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_addr  (rd_addr[r*AW +: AW]),
            .rd_en    (rd_en[r]),
            .arr_word (arr_word[r*DW +: DW]),
            .pend_addr(pend_addr),
            .pend_data(pend_data),
            .pend_en  (pend_en),
            .rd_data  (rd_data[r*DW +: DW])
        );
    end

endmodule

// File: tb/tb_rf_delayed_ram.sv
// Bench: compares each read port, every cycle, with a read-first model
// that returns the stored word and then applies the same edge's writes.
module tb_rf_delayed_ram;
    localparam int AW = 3, DW = 16, LANES = 4, EG = 2, NWR = 2, NRD = 2;
    localparam int LW = DW / LANES;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0]    wa [NWR];
    logic [DW-1:0]    wd [NWR];
    logic [LANES-1:0] we [NWR];
    logic [AW-1:0]    ra [NRD];
    logic             re [NRD];

    logic [NWR*AW-1:0]    wr_addr;
    logic [NWR*DW-1:0]    wr_data;
    logic [NWR*LANES-1:0] wr_lane_en;
    logic [NRD*AW-1:0]    rd_addr;
    logic [NRD-1:0]       rd_en;
    logic [NRD*DW-1:0]    rd_data;

    logic [DW-1:0] mm    [DEPTH];
    logic [DW-1:0] exp_q [NRD];
    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NWR; p++) begin
            wr_addr[p*AW +: AW]       = wa[p];
            wr_data[p*DW +: DW]       = wd[p];
            wr_lane_en[p*LANES +: LANES] = we[p];
        end
        for (int r = 0; r < NRD; r++) begin
            rd_addr[r*AW +: AW] = ra[r];
            rd_en[r]            = re[r];
        end
    end

    rf_delayed_ram #(
        .AW(AW), .DW(DW), .LANES(LANES), .EN_GROUP(EG), .NWR(NWR), .NRD(NRD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_lane_en(wr_lane_en), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data)
    );

    task automatic idle();
        for (int p = 0; p < NWR; p++) begin wa[p] = '0; wd[p] = '0; we[p] = '0; end
        for (int r = 0; r < NRD; r++) begin ra[r] = '0; re[r] = 1'b0; end
    endtask

    // One clock edge: model result first, then model writes (R9 grouping).
    task automatic tick(input string tag);
        for (int r = 0; r < NRD; r++) begin
            if (!rst_n)     exp_q[r] = '0;
            else if (re[r]) exp_q[r] = mm[ra[r]];
        end
        if (rst_n) begin
            for (int p = 0; p < NWR; p++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (|we[p][(l/EG)*EG +: EG]) mm[wa[p]][l*LW +: LW] = wd[p][l*LW +: LW];
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int r = 0; r < NRD; r++) begin
            vectors++;
            if (rd_data[r*DW +: DW] !== exp_q[r]) begin
                miscompares++;
                $display("FAIL %s read port %0d: got %h expected %h", tag, r,
                         rd_data[r*DW +: DW], exp_q[r]);
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        idle();
        for (int a = 0; a < DEPTH; a++) mm[a] = '0;
        // R1: reset clears read data
        re[0] = 1'b1; re[1] = 1'b1;
        tick("R1"); tick("R1");
        rst_n = 1'b1;
        idle();
        // Fill every address with full-lane writes (R5 setup)
        for (int a = 0; a < DEPTH; a++) begin
            wa[0] = AW'(a); wd[0] = 16'h1000 + 16'(a * 16'h0111); we[0] = 4'hF;
            tick("R5");
        end
        idle(); tick("R5");
        for (int a = 0; a < DEPTH; a++) begin
            ra[0] = AW'(a); re[0] = 1'b1; ra[1] = AW'(DEPTH-1-a); re[1] = 1'b1;
            tick("R5");
        end
        // R2: write during reset is dropped; R1: nothing commits after release
        idle(); rst_n = 1'b0;
        wa[0] = 3'd2; wd[0] = 16'hBEEF; we[0] = 4'hF; tick("R2");
        rst_n = 1'b1; idle(); tick("R1");
        ra[0] = 3'd2; re[0] = 1'b1; tick("R2"); tick("R2");
        // R3, R4, R5: same edge, next edge, later edge
        idle();
        wa[0] = 3'd3; wd[0] = 16'hA5A5; we[0] = 4'hF; ra[0] = 3'd3; re[0] = 1'b1;
        tick("R3");
        idle(); ra[0] = 3'd3; re[0] = 1'b1; tick("R4");
        idle(); tick("R5");
        ra[0] = 3'd3; re[0] = 1'b1; tick("R5");
        // R6, R9: partial group enables
        idle(); wa[0] = 3'd4; wd[0] = 16'h1234; we[0] = 4'b0100; tick("R6");
        idle(); wa[0] = 3'd4; wd[0] = 16'hCDEF; we[0] = 4'b0010;
        ra[0] = 3'd4; re[0] = 1'b1; tick("R9");
        idle(); ra[0] = 3'd4; re[0] = 1'b1; tick("R9"); tick("R6");
        // R7: two ports, same address, full then partial
        idle(); wa[0] = 3'd5; wd[0] = 16'h1111; we[0] = 4'hF;
        wa[1] = 3'd5; wd[1] = 16'h2222; we[1] = 4'hF; tick("R7");
        idle(); ra[0] = 3'd5; re[0] = 1'b1; ra[1] = 3'd5; re[1] = 1'b1; tick("R7");
        tick("R7");
        idle(); wa[0] = 3'd6; wd[0] = 16'h3333; we[0] = 4'hF;
        wa[1] = 3'd6; wd[1] = 16'h4444; we[1] = 4'b0001; tick("R7");
        idle(); ra[1] = 3'd6; re[1] = 1'b1; tick("R7");
        tick("R7");
        // R8: hold with changing address and write activity
        idle(); ra[0] = 3'd0; ra[1] = 3'd7; re[0] = 1'b0; re[1] = 1'b0;
        wa[0] = 3'd7; wd[0] = 16'h7777; we[0] = 4'hF; tick("R8");
        idle(); ra[0] = 3'd1; tick("R8");
        // R10: two ports, distinct addresses, one forwarded
        wa[1] = 3'd1; wd[1] = 16'h5A5A; we[1] = 4'hF; tick("R10");
        idle(); ra[0] = 3'd1; re[0] = 1'b1; ra[1] = 3'd7; re[1] = 1'b1; tick("R10");
        // Random collisions over a narrow window (R3, R4, R7)
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < NWR; p++) begin
                wa[p] = AW'($urandom_range(0, 3));
                wd[p] = DW'($urandom);
                we[p] = LANES'($urandom);
            end
            for (int r = 0; r < NRD; r++) begin
                ra[r] = AW'($urandom_range(0, 3));
                re[r] = ($urandom_range(0, 3) != 0);
            end
            tick("R3/R4/R7 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule